// File: doc/BRIEF.md
# CAN Local Power-Down and Wake-Up Controller

This block runs the handshake between software and a CAN controller for entering and leaving a local low-power state. Software writes three control bits: a power-down request, a wake-on-bus-activity enable and the controller's initialisation bit. When a power-down request is pending, the block waits until the protocol engine reports that the bus is idle, so that no frame in progress is cut off. It then raises a power-down acknowledge status bit and, one cycle later, drops the enable for the gated local clocks.

While the clocks are off, a synchronised and filtered dominant level on the receive line wakes the controller, provided the wake enable is set. On such a wake the block turns the local clocks back on, gives a one-cycle wake indication, sets the initialisation bit and clears the power-down request. Because the initialisation bit is set, the frame that caused the wake is never received. Software can also end the low-power state by clearing the request itself; it must then clear the initialisation bit to resume traffic. In both cases the acknowledge bit stays high for a set number of cycles after the clocks restart and then clears.

The block runs entirely on a free-running clock. The receive line passes through a synchroniser with a configurable number of stages. A wake needs a configurable number of consecutive dominant samples.

Top module: `can_lpm_ctrl`

## Requirements
- R1: Out of reset the power-down request and the wake enable read 0, the initialisation bit reads 1, the acknowledge reads 0, the clock enable reads 1 and the wake indication reads 0.
- R2: A cycle with `cfg_wr` high loads all three control bits from the `cfg_*` inputs at that clock edge, except when a wake event happens at the same edge (see R6).
- R3: With the request set, the acknowledge does not rise while `eng_idle` is low. It rises at the first edge where the request and `eng_idle` are both high.
- R4: In the first cycle that the acknowledge is high, the clock enable is still high.
- R5: The clock enable goes low one cycle after the acknowledge rises and stays low until a wake event occurs or the request is cleared.
- R6: While the clocks are off and the wake enable is 1, a dominant (0) level on `can_rx` held for WAKE_FILTER consecutive synchronised samples is a wake event. At the next edge the clock enable goes high, `wake_pulse` is high for exactly one cycle, the initialisation bit is set and the request is cleared.
- R7: With the wake enable at 0, a dominant level while the clocks are off does not wake the block.
- R8: A dominant run shorter than WAKE_FILTER synchronised samples does not wake the block.
- R9: If software clears the request while the clocks are off, the clocks restart without a wake indication, and the initialisation bit keeps the value software wrote.
- R10: After the clocks restart, the acknowledge stays high for RESTART_CYC cycles and then clears.
- R11: A dominant level while the block is not powered down has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the three control bits |
| cfg_pd_req | input | 1 | Power-down request value to write |
| cfg_wake_en | input | 1 | Wake-on-bus-activity enable value to write |
| cfg_init | input | 1 | Initialisation bit value to write |
| eng_idle | input | 1 | Protocol engine reports the bus as idle |
| can_rx | input | 1 | Asynchronous CAN receive line, 0 is dominant |
| ctl_pd_req | output | 1 | Current power-down request bit |
| ctl_wake_en | output | 1 | Current wake enable bit |
| ctl_init | output | 1 | Current initialisation bit |
| stat_pd_ack | output | 1 | Power-down acknowledge status |
| lclk_en | output | 1 | Enable for the gated local clocks |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
On every cycle the assertions check the ordering rules. The acknowledge only rises after an idle bus. The clocks only stop under an acknowledge and restart with the acknowledge still high. A wake pulse is a single cycle, needs the wake enable and leaves the initialisation bit set and the request cleared. The bench's scenarios are the only place to see the actual latencies. These cover synchroniser depth plus filter length, a glitch shorter than the filter, a dominant level while running or with wakes disabled, and the exact length of the acknowledge tail. For these the bench compares every output on every cycle against its behavioural model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_ACK     = 2'd1,
      ST_OFF     = 2'd2,
      ST_RESTORE = 2'd3
   } lpm_state_t;
endpackage

// File: rtl/lpm_rx_sync.sv
module lpm_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_async,
   output logic rx_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpm_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;   // recessive
      else        chain_q <= {chain_q[STAGES-2:0], rx_async};
   end

   assign rx_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_dom_detect.sv
module lpm_dom_detect #(
   parameter int FILTER = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic rx_sync,
   output logic dom_hit
);
   generate
      if (FILTER < 1) begin : g_bad_filter
         $error("lpm_dom_detect: FILTER must be at least 1");
      end
      if (FILTER == 1) begin : g_direct
         assign dom_hit = armed & ~rx_sync;
      end else begin : g_count
         localparam int CW = $clog2(FILTER);
         localparam logic [CW-1:0] LAST = CW'(FILTER - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                run_q <= '0;
            else if (!(armed && !rx_sync)) run_q <= '0;
            else if (run_q != LAST)    run_q <= run_q + 1'b1;
         end
         assign dom_hit = armed & ~rx_sync & (run_q == LAST);

         AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            run_q <= LAST);                                             // R8
      end
   endgenerate
endmodule

// File: rtl/lpm_ctl_regs.sv
module lpm_ctl_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_pd_req,
   input  logic wr_wake_en,
   input  logic wr_init,
   input  logic wake_evt,
   output logic pd_req,
   output logic wake_en,
   output logic init
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_req  <= 1'b0;
         wake_en <= 1'b0;
         init    <= 1'b1;
      end else begin
         if (wr) wake_en <= wr_wake_en;
         if (wake_evt) begin
            pd_req <= 1'b0;
            init   <= 1'b1;
         end else if (wr) begin
            pd_req <= wr_pd_req;
            init   <= wr_init;
         end
      end
   end

   AST_WAKE_SETS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> (init && !pd_req));                                  // R6
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm #(
   parameter int RESTART_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic eng_idle,
   input  logic dom_hit,
   output logic pwr_off,
   output logic wake_evt,
   output logic pd_ack,
   output logic clk_en,
   output logic wake_pulse
);
   import lpm_pkg::*;

   generate
      if (RESTART_CYC < 1) begin : g_bad_restart
         $error("lpm_fsm: RESTART_CYC must be at least 1");
      end
   endgenerate

   localparam int RW = (RESTART_CYC > 1) ? $clog2(RESTART_CYC) : 1;
   localparam logic [RW-1:0] RLAST = RW'(RESTART_CYC - 1);

   lpm_state_t state_q, state_d;
   logic [RW-1:0] rcnt_q;

   assign pwr_off  = (state_q == ST_OFF);
   assign wake_evt = pwr_off & dom_hit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (pd_req && eng_idle) state_d = ST_ACK;
         ST_ACK:     state_d = ST_OFF;
         ST_OFF:     if (dom_hit || !pd_req) state_d = ST_RESTORE;
         ST_RESTORE: if (rcnt_q == RLAST) state_d = ST_RUN;
         default:    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         rcnt_q     <= '0;
         wake_pulse <= 1'b0;
      end else begin
         state_q    <= state_d;
         wake_pulse <= wake_evt;
         if (state_q == ST_RESTORE && rcnt_q != RLAST) rcnt_q <= rcnt_q + 1'b1;
         else                                          rcnt_q <= '0;
      end
   end

   assign pd_ack = (state_q != ST_RUN);
   assign clk_en = (state_q != ST_OFF);

   AST_ACK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_ack) |-> $past(eng_idle));                               // R3
   AST_GATE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> ($past(pd_ack) && pd_ack));                     // R5
   AST_RESTART_KEEPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> pd_ack);                                        // R10
   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);                                      // R6
   AST_WAKE_CLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> clk_en);                                           // R6
endmodule

// File: rtl/can_lpm_ctrl.sv
module can_lpm_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int WAKE_FILTER = 3,
   parameter int RESTART_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_pd_req,
   input  logic cfg_wake_en,
   input  logic cfg_init,
   input  logic eng_idle,
   input  logic can_rx,
   output logic ctl_pd_req,
   output logic ctl_wake_en,
   output logic ctl_init,
   output logic stat_pd_ack,
   output logic lclk_en,
   output logic wake_pulse
);
   logic rx_s, armed, dom_hit, pwr_off, wake_evt;

   lpm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rx_async(can_rx), .rx_sync(rx_s));

   assign armed = pwr_off & ctl_wake_en;

   lpm_dom_detect #(.FILTER(WAKE_FILTER)) u_dom (
      .clk(clk), .rst_n(rst_n), .armed(armed), .rx_sync(rx_s), .dom_hit(dom_hit));

   lpm_ctl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_pd_req(cfg_pd_req),
      .wr_wake_en(cfg_wake_en), .wr_init(cfg_init), .wake_evt(wake_evt),
      .pd_req(ctl_pd_req), .wake_en(ctl_wake_en), .init(ctl_init));

   lpm_fsm #(.RESTART_CYC(RESTART_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pd_req(ctl_pd_req), .eng_idle(eng_idle),
      .dom_hit(dom_hit), .pwr_off(pwr_off), .wake_evt(wake_evt),
      .pd_ack(stat_pd_ack), .clk_en(lclk_en), .wake_pulse(wake_pulse));

   AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(ctl_wake_en));                               // R7
   AST_CLOCKS_OFF_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lclk_en |-> stat_pd_ack);                                        // R5
endmodule

// File: tb/can_lpm_ctrl_bench.sv
`timescale 1ns/1ps
module can_lpm_ctrl_bench;
   localparam int SYNC = 2;
   localparam int FILT = 3;
   localparam int REST = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_pd_req = 1'b0, cfg_wake_en = 1'b0, cfg_init = 1'b0;
   logic eng_idle = 1'b0, can_rx = 1'b1;
   logic ctl_pd_req, ctl_wake_en, ctl_init, stat_pd_ack, lclk_en, wake_pulse;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   can_lpm_ctrl #(.SYNC_STAGES(SYNC), .WAKE_FILTER(FILT), .RESTART_CYC(REST)) u_can_lpm_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pd_req(cfg_pd_req),
      .cfg_wake_en(cfg_wake_en), .cfg_init(cfg_init), .eng_idle(eng_idle),
      .can_rx(can_rx), .ctl_pd_req(ctl_pd_req), .ctl_wake_en(ctl_wake_en),
      .ctl_init(ctl_init), .stat_pd_ack(stat_pd_ack), .lclk_en(lclk_en),
      .wake_pulse(wake_pulse));

   // behavioural reference: mode 0 running, 1 acknowledging, 2 off, 3 restarting
   int  m_mode = 0;
   int  m_tail = 0;
   int  m_run  = 0;
   bit  m_pd = 0, m_we = 0, m_init = 1, m_wake = 0;
   bit  rxq[$];

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_tail = 0; m_run = 0;
         m_pd = 0; m_we = 0; m_init = 1; m_wake = 0;
         rxq = {};
         for (int i = 0; i < SYNC; i++) rxq.push_back(1'b1);
      end else begin
         bit rx_seen, dominant, woke;
         int next_mode;
         rx_seen  = rxq[SYNC-1];
         dominant = (m_mode == 2) && m_we && !rx_seen;
         woke     = dominant && (m_run >= FILT - 1);
         next_mode = m_mode;
         case (m_mode)
            0: if (m_pd && eng_idle) next_mode = 1;
            1: next_mode = 2;
            2: if (woke || !m_pd) next_mode = 3;
            default: if (m_tail == REST - 1) next_mode = 0;
         endcase
         m_tail = (m_mode == 3 && m_tail != REST - 1) ? m_tail + 1 : 0;
         m_run  = dominant ? m_run + 1 : 0;
         m_wake = woke;
         if (cfg_wr) m_we = cfg_wake_en;
         if (woke) begin m_pd = 0; m_init = 1; end
         else if (cfg_wr) begin m_pd = cfg_pd_req; m_init = cfg_init; end
         m_mode = next_mode;
         rxq.push_front(can_rx);
         void'(rxq.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 pd_req",    ctl_pd_req,  m_pd);
         chk("R2 wake_en",   ctl_wake_en, m_we);
         chk("R6/R9 init",   ctl_init,    m_init);
         chk("R3/R10 ack",   stat_pd_ack, (m_mode != 0));
         chk("R4/R5 clk_en", lclk_en,     (m_mode != 2));
         chk("R6/R8 wake",   wake_pulse,  m_wake);
      end
   end

   task automatic wr(input bit pd, input bit we, input bit ini);
      @(negedge clk);
      cfg_wr = 1; cfg_pd_req = pd; cfg_wake_en = we; cfg_init = ini;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic dom(input int n);
      can_rx = 0;
      repeat (n) @(negedge clk);
      can_rx = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pd_req",  ctl_pd_req,  1'b0);
      chk("R1 wake_en", ctl_wake_en, 1'b0);
      chk("R1 init",    ctl_init,    1'b1);
      chk("R1 ack",     stat_pd_ack, 1'b0);
      chk("R1 clk_en",  lclk_en,     1'b1);
      chk("R1 wake",    wake_pulse,  1'b0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // R11 dominant while running
      dom(8);
      repeat (5) @(negedge clk);
      chk("R11 clk_en", lclk_en, 1'b1);
      // R3 request held off by busy engine
      wr(1, 1, 0);
      repeat (6) @(negedge clk);
      chk("R3 no ack while busy", stat_pd_ack, 1'b0);
      eng_idle = 1;
      @(negedge clk);
      chk("R4 ack up, clocks on", stat_pd_ack & lclk_en, 1'b1);
      @(negedge clk);
      chk("R5 clocks off", lclk_en, 1'b0);
      repeat (4) @(negedge clk);
      // R8 short glitch
      dom(FILT - 1);
      repeat (8) @(negedge clk);
      chk("R8 still off", lclk_en, 1'b0);
      // R6 wake
      dom(FILT + 3);
      repeat (REST + 6) @(negedge clk);
      chk("R6 init set", ctl_init, 1'b1);
      chk("R6 pd_req cleared", ctl_pd_req, 1'b0);
      chk("R10 ack cleared", stat_pd_ack, 1'b0);
      // R9 software exit
      wr(1, 1, 0);
      repeat (5) @(negedge clk);
      wr(0, 1, 0);
      repeat (REST + 4) @(negedge clk);
      chk("R9 init kept", ctl_init, 1'b0);
      chk("R9 clocks on", lclk_en, 1'b1);
      // R7 wakes disabled
      wr(1, 0, 0);
      repeat (4) @(negedge clk);
      dom(10);
      repeat (6) @(negedge clk);
      chk("R7 still off", lclk_en, 1'b0);
      wr(0, 0, 0);
      repeat (REST + 4) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule